// File: doc/BRIEF.md
# Reader Interrupt Status and Collision Capture

This block collects event pulses from the framing logic of a contactless reader and turns them into one interrupt request. The sources are the transmit path, the receive path, a FIFO fill-level monitor, the CRC, parity and framing/EOF checkers, the collision detector and the no-response timer. Each event sets one flag in a status byte. Transmit and receive set their flags when the activity begins, but they raise the interrupt only when the activity completes. The other six flags raise the interrupt through individual enable bits.

The block also records the bit position of a collision, or of a frame error in protocols without collision detection. The position is 10 bits wide. It is captured on the first qualifying event and held until software reads it. Three byte-wide registers are reachable on a simple address/read/write bus. Reading status returns it and clears it, which drops the interrupt request. Writing the protocol control address also clears status.

Top module: `rdr_irq_ctrl`

## Requirements
- R1: After rst_n is low, and in the cycle after any cycle with enable low, status (address 0xC) reads 0x00, the mask register (0xD) reads 0x3E, position low (0xE) reads 0x00, and irq is 0. Events that arrive while enable is low are ignored.
- R2: Status bit positions are: tx_start or tx_done sets bit 7, rx_sof or rx_done sets bit 6, crc_err sets bit 4, par_err sets bit 3, frm_err sets bit 2, col_det sets bit 1 and no_resp sets bit 0. Each takes effect on the clock edge that samples the pulse.
- R3: A fifo_upd strobe sets status bit 5 only when fifo_lvl is below 4 or above 8. Levels 4 to 8 inclusive leave the flag unchanged.
- R4: tx_start and rx_sof do not raise irq. tx_done and rx_done raise irq whatever the mask holds, and it stays high until status is cleared.
- R5: Mask register bits 5..0 are the enables for status bits 5..0 and are written through address 0xD. irq is high when any status bit in 5..0 is set together with its enable bit, or when a TX or RX completion is pending.
- R6: A read of address 0xC returns the status value held before the read. The read then clears status and any pending completions, so irq is 0 in the following cycle unless a new event arrived.
- R7: A write to address 0x0 (the protocol control register) clears status and pending completions in the same way as a status read.
- R8: An event that arrives in the same cycle as a status clear is kept: its flag is set after the clear.
- R9: The first crc_err, par_err, frm_err or col_det after the position was cleared captures err_pos. Bits 9..8 read as 0xD bits 7..6, and bits 7..0 read as address 0xE.
- R10: Later position events leave the captured value unchanged. Reading 0xD does not clear it. Reading 0xE returns it, then clears all 10 bits and re-arms capture.
- R11: Read data is registered. rdata shows the addressed register in the cycle after rd_en, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| enable | input | 1 | Block enable; low holds all registers at reset values |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tx_start | input | 1 | Transmission started |
| tx_done | input | 1 | Transmission finished |
| rx_sof | input | 1 | Start-of-frame received |
| rx_done | input | 1 | Reception finished |
| fifo_upd | input | 1 | FIFO level sample strobe |
| fifo_lvl | input | 4 | FIFO fill level |
| crc_err | input | 1 | CRC error pulse |
| par_err | input | 1 | Parity error pulse |
| frm_err | input | 1 | Framing or EOF error pulse |
| col_det | input | 1 | Collision detected pulse |
| no_resp | input | 1 | No-response timeout pulse |
| err_pos | input | 10 | Bit position valid with an error or collision pulse |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. A clear with no new event empties status and drops irq. An event that lands during a clear survives. A TX completion never pends without its status flag. The first position event is captured, and a held position does not change until it is read. Disabling the block restores the mask and read data. Other behaviour shows only in the bench's scenarios, which read registers through the bus: the status bit layout, the FIFO band edges at levels 4 and 8, the effect of the default and written masks on irq, and the way reads of 0xD and 0xE affect the position.

// File: rtl/rdr_irq_pkg.sv
package rdr_irq_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int POS_W  = 10;
    localparam int EN_W   = 6;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'hC;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'hD;
    localparam logic [ADDR_W-1:0] A_POSLO = 4'hE;

    localparam logic [EN_W-1:0] MASK_RST = 6'h3E;

    // Field order is the register bit order, MSB first.
    typedef struct packed {
        logic tx;
        logic rx;
        logic fifo;
        logic crc;
        logic par;
        logic frm;
        logic col;
        logic nrsp;
    } irq_stat_t;

    typedef struct packed {
        logic tx_start;
        logic tx_done;
        logic rx_sof;
        logic rx_done;
        logic fifo_hit;
        logic crc;
        logic par;
        logic frm;
        logic col;
        logic nrsp;
    } irq_evt_t;

endpackage

// File: rtl/rdr_irq_fifomon.sv
module rdr_irq_fifomon #(
    parameter int LVL_W = 4,
    parameter int LO    = 4,
    parameter int HI    = 8
) (
    input  logic             upd,
    input  logic [LVL_W-1:0] lvl,
    output logic             hit
);
    localparam logic [LVL_W-1:0] LO_V = LVL_W'(LO);
    localparam logic [LVL_W-1:0] HI_V = LVL_W'(HI);

    always_comb begin
        hit = upd && ((lvl < LO_V) || (lvl > HI_V));
    end
endmodule

// File: rtl/rdr_irq_flags.sv
module rdr_irq_flags
    import rdr_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  irq_evt_t        evt,
    input  logic            clr,
    input  logic [EN_W-1:0] mask,
    output irq_stat_t       stat,
    output logic            irq
);
    typedef struct packed {
        irq_stat_t stat;
        logic      tx_pend;
        logic      rx_pend;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [DATA_W-1:0] stat_bits;
    logic              evt_any;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end
        // Events are applied after the clear so that they win.
        if (evt.tx_start || evt.tx_done) st_d.stat.tx   = 1'b1;
        if (evt.rx_sof   || evt.rx_done) st_d.stat.rx   = 1'b1;
        if (evt.fifo_hit)                st_d.stat.fifo = 1'b1;
        if (evt.crc)                     st_d.stat.crc  = 1'b1;
        if (evt.par)                     st_d.stat.par  = 1'b1;
        if (evt.frm)                     st_d.stat.frm  = 1'b1;
        if (evt.col)                     st_d.stat.col  = 1'b1;
        if (evt.nrsp)                    st_d.stat.nrsp = 1'b1;
        if (evt.tx_done)                 st_d.tx_pend   = 1'b1;
        if (evt.rx_done)                 st_d.rx_pend   = 1'b1;
        if (!enable) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_bits = st_q.stat;
        evt_any   = |evt;
        stat      = st_q.stat;
        irq       = st_q.tx_pend || st_q.rx_pend || (|(stat_bits[EN_W-1:0] & mask));
    end

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && enable && !evt_any) |=> (stat == '0 && !irq));

    assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && enable && evt.crc) |=> stat.crc);

    assert_tx_flag_before_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tx_pend) |-> stat.tx);

endmodule

// File: rtl/rdr_irq_colpos.sv
module rdr_irq_colpos
    import rdr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pos_evt,
    input  logic [POS_W-1:0] pos_in,
    input  logic             rd_clr,
    output logic [POS_W-1:0] pos
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             vld;
    } pos_st_t;

    pos_st_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (rd_clr) begin
            ps_d = '0;
        end
        if (pos_evt && (!ps_q.vld || rd_clr)) begin
            ps_d.pos = pos_in;
            ps_d.vld = 1'b1;
        end
        if (!enable) begin
            ps_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign pos = ps_q.pos;

    assert_pos_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q.vld && !rd_clr && enable) |=> $stable(pos));

    assert_first_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_q.vld && pos_evt && enable) |=> (pos == $past(pos_in)));

endmodule

// File: rtl/rdr_irq_regif.sv
module rdr_irq_regif
    import rdr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  irq_stat_t         stat,
    input  logic [POS_W-1:0]  pos,
    output logic [DATA_W-1:0] rdata,
    output logic [EN_W-1:0]   mask,
    output logic              stat_clr,
    output logic              pos_clr
);
    localparam int HI_W = POS_W - 8;

    typedef struct packed {
        logic [EN_W-1:0]   mask;
        logic [DATA_W-1:0] rdata;
    } rif_st_t;

    rif_st_t rs_d, rs_q;
    logic    wdata_unused;

    always_comb begin
        rs_d     = rs_q;
        stat_clr = enable && ((rd_en && addr == A_STAT) || (wr_en && addr == A_CTRL));
        pos_clr  = enable && rd_en && addr == A_POSLO;
        if (wr_en && addr == A_MASK) begin
            rs_d.mask = wdata[EN_W-1:0];
        end
        if (rd_en) begin
            case (addr)
                A_STAT:  rs_d.rdata = stat;
                A_MASK:  rs_d.rdata = {pos[POS_W-1 -: HI_W], rs_q.mask};
                A_POSLO: rs_d.rdata = pos[7:0];
                default: rs_d.rdata = '0;
            endcase
        end
        if (!enable) begin
            rs_d.mask  = MASK_RST;
            rs_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q.mask  <= MASK_RST;
            rs_q.rdata <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign wdata_unused = ^wdata[DATA_W-1:EN_W];
    assign mask  = rs_q.mask;
    assign rdata = rs_q.rdata;

    assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (mask == MASK_RST && rdata == '0));

endmodule

// File: rtl/rdr_irq_ctrl.sv
module rdr_irq_ctrl
    import rdr_irq_pkg::*;
#(
    parameter int LVL_W   = 4,
    parameter int FIFO_LO = 4,
    parameter int FIFO_HI = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              rx_sof,
    input  logic              rx_done,
    input  logic              fifo_upd,
    input  logic [LVL_W-1:0]  fifo_lvl,
    input  logic              crc_err,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              col_det,
    input  logic              no_resp,
    input  logic [POS_W-1:0]  err_pos,
    output logic              irq
);
    irq_evt_t          evt;
    irq_stat_t         stat;
    logic              fifo_hit;
    logic [EN_W-1:0]   mask;
    logic [POS_W-1:0]  pos;
    logic              stat_clr;
    logic              pos_clr;
    logic              pos_evt;

    rdr_irq_fifomon #(.LVL_W(LVL_W), .LO(FIFO_LO), .HI(FIFO_HI)) u_fifomon (
        .upd (fifo_upd),
        .lvl (fifo_lvl),
        .hit (fifo_hit)
    );

    always_comb begin
        evt.tx_start = tx_start;
        evt.tx_done  = tx_done;
        evt.rx_sof   = rx_sof;
        evt.rx_done  = rx_done;
        evt.fifo_hit = fifo_hit;
        evt.crc      = crc_err;
        evt.par      = par_err;
        evt.frm      = frm_err;
        evt.col      = col_det;
        evt.nrsp     = no_resp;
        pos_evt      = crc_err || par_err || frm_err || col_det;
    end

    rdr_irq_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .evt    (evt),
        .clr    (stat_clr),
        .mask   (mask),
        .stat   (stat),
        .irq    (irq)
    );

    rdr_irq_colpos u_colpos (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .pos_evt (pos_evt),
        .pos_in  (err_pos),
        .rd_clr  (pos_clr),
        .pos     (pos)
    );

    rdr_irq_regif u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .addr     (addr),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .stat     (stat),
        .pos      (pos),
        .rdata    (rdata),
        .mask     (mask),
        .stat_clr (stat_clr),
        .pos_clr  (pos_clr)
    );

endmodule

// File: tb/rdr_irq_ctrl_tb.sv
module rdr_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    localparam int E_TXS = 9, E_TXD = 8, E_RXS = 7, E_RXD = 6, E_FIFO = 5;
    localparam int E_CRC = 4, E_PAR = 3, E_FRM = 2, E_COL = 1, E_NR = 0;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       enable = 1;
    logic [3:0] addr = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       tx_start = 0, tx_done = 0, rx_sof = 0, rx_done = 0, fifo_upd = 0;
    logic [3:0] fifo_lvl = 0;
    logic       crc_err = 0, par_err = 0, frm_err = 0, col_det = 0, no_resp = 0;
    logic [9:0] err_pos = 0;
    logic       irq;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdr_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .tx_start(tx_start),
        .tx_done(tx_done), .rx_sof(rx_sof), .rx_done(rx_done), .fifo_upd(fifo_upd),
        .fifo_lvl(fifo_lvl), .crc_err(crc_err), .par_err(par_err), .frm_err(frm_err),
        .col_det(col_det), .no_resp(no_resp), .err_pos(err_pos), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic set_evt(input logic [9:0] v, input logic [9:0] pos, input logic [3:0] lvl);
        tx_start = v[E_TXS]; tx_done = v[E_TXD]; rx_sof = v[E_RXS]; rx_done = v[E_RXD];
        fifo_upd = v[E_FIFO]; crc_err = v[E_CRC]; par_err = v[E_PAR]; frm_err = v[E_FRM];
        col_det = v[E_COL]; no_resp = v[E_NR]; err_pos = pos; fifo_lvl = lvl;
    endtask

    task automatic fire(input int bitn, input logic [9:0] pos, input logic [3:0] lvl);
        @(negedge clk);
        set_evt(10'b1 << bitn, pos, lvl);
        @(negedge clk);
        set_evt('0, '0, '0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd(4'hC, d); chk("R1 status reset", d, 8'h00);
        rd(4'hD, d); chk("R1 mask reset", d, 8'h3E);
        rd(4'hE, d); chk("R1 poslo reset", d, 8'h00);
        rd(4'h7, d); chk("R11 unmapped read", d, 8'h00);
    endtask

    task automatic t_bits();
        logic [7:0] d;
        int         bits[7] = '{E_TXS, E_RXS, E_CRC, E_PAR, E_FRM, E_COL, E_NR};
        logic [7:0] expv[7] = '{8'h80, 8'h40, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01};
        for (int i = 0; i < 7; i++) begin
            fire(bits[i], 10'h000, 4'h6);
            rd(4'hC, d); chk("R2 status bit", d, expv[i]);
            rd(4'hE, d);
        end
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        logic [3:0] lv[6] = '{4'd4, 4'd8, 4'd6, 4'd3, 4'd9, 4'd0};
        logic [7:0] ex[6] = '{8'h00, 8'h00, 8'h00, 8'h20, 8'h20, 8'h20};
        for (int i = 0; i < 6; i++) begin
            fire(E_FIFO, 10'h000, lv[i]);
            chk("R3 fifo irq", {7'b0, irq}, {7'b0, ex[i][5]});
            rd(4'hC, d); chk("R3 fifo band", d, ex[i]);
        end
    endtask

    task automatic t_deferred();
        logic [7:0] d;
        wr(4'hD, 8'h00);
        fire(E_TXS, 10'h000, 4'h6);
        chk("R4 no irq at tx start", {7'b0, irq}, 8'h00);
        fire(E_TXD, 10'h000, 4'h6);
        chk("R4 irq at tx done unmasked", {7'b0, irq}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R4 irq held", {7'b0, irq}, 8'h01);
        rd(4'hC, d); chk("R4 tx status", d, 8'h80);
        chk("R6 irq dropped after read", {7'b0, irq}, 8'h00);
        fire(E_RXS, 10'h000, 4'h6);
        chk("R4 no irq at rx sof", {7'b0, irq}, 8'h00);
        fire(E_RXD, 10'h000, 4'h6);
        chk("R4 irq at rx done", {7'b0, irq}, 8'h01);
        rd(4'hC, d); chk("R6 rx status read", d, 8'h40);
        rd(4'hC, d); chk("R6 status empty after read", d, 8'h00);
        wr(4'hD, 8'h3E);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        fire(E_NR, 10'h000, 4'h6);
        chk("R5 default mask blocks no_resp", {7'b0, irq}, 8'h00);
        rd(4'hC, d); chk("R5 no_resp flag", d, 8'h01);
        wr(4'hD, 8'hC1);
        rd(4'hD, d); chk("R5 mask write low bits only", d, 8'h01);
        fire(E_CRC, 10'h000, 4'h6);
        chk("R5 masked crc no irq", {7'b0, irq}, 8'h00);
        fire(E_NR, 10'h000, 4'h6);
        chk("R5 enabled no_resp irq", {7'b0, irq}, 8'h01);
        rd(4'hC, d); chk("R5 status both", d, 8'h11);
        chk("R6 irq low", {7'b0, irq}, 8'h00);
        rd(4'hE, d);
        wr(4'hD, 8'h3E);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        fire(E_CRC, 10'h000, 4'h6);
        fire(E_TXD, 10'h000, 4'h6);
        chk("R7 irq before ctrl write", {7'b0, irq}, 8'h01);
        wr(4'h0, 8'h5A);
        chk("R7 irq after ctrl write", {7'b0, irq}, 8'h00);
        rd(4'hC, d); chk("R7 status after ctrl write", d, 8'h00);
        rd(4'hE, d);
    endtask

    task automatic t_race();
        logic [7:0] d;
        fire(E_CRC, 10'h000, 4'h6);
        @(negedge clk);
        addr = 4'hC; rd_en = 1; set_evt(10'b1 << E_PAR, 10'h000, 4'h6);
        @(negedge clk);
        rd_en = 0; set_evt('0, '0, '0);
        chk("R8 read value before clear", rdata, 8'h10);
        chk("R8 irq from surviving event", {7'b0, irq}, 8'h01);
        rd(4'hC, d); chk("R8 surviving flag", d, 8'h08);
        rd(4'hE, d);
    endtask

    task automatic t_pos();
        logic [7:0] d;
        fire(E_COL, 10'h2A5, 4'h6);
        rd(4'hD, d); chk("R9 pos high bits", d, 8'hBE);
        fire(E_CRC, 10'h011, 4'h6);
        rd(4'hD, d); chk("R10 0xD read keeps pos", d, 8'hBE);
        rd(4'hE, d); chk("R9 pos low", d, 8'hA5);
        rd(4'hE, d); chk("R10 pos cleared", d, 8'h00);
        rd(4'hD, d); chk("R10 high cleared", d, 8'h3E);
        fire(E_FRM, 10'h155, 4'h6);
        rd(4'hE, d); chk("R10 recapture low", d, 8'h55);
        rd(4'hC, d);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(4'hD, 8'h00);
        fire(E_COL, 10'h3FF, 4'h6);
        fire(E_TXD, 10'h000, 4'h6);
        @(negedge clk); enable = 0;
        set_evt(10'b1 << E_CRC, 10'h0F0, 4'h6);
        @(negedge clk); set_evt('0, '0, '0);
        chk("R1 irq while disabled", {7'b0, irq}, 8'h00);
        enable = 1;
        rd(4'hD, d); chk("R1 mask after enable low", d, 8'h3E);
        rd(4'hC, d); chk("R1 status after enable low", d, 8'h00);
        rd(4'hE, d); chk("R1 pos after enable low", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bits();
        t_fifo();
        t_deferred();
        t_mask();
        t_ctrl();
        t_race();
        t_pos();
        t_enable();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule